// File: doc/BRIEF.md
# Priority Reference Clock Selector

This block decides which of several reference inputs feeds the main timing loop. It does not touch the clocks. It works on per-input validity flags and 4-bit priority codes, and it produces the index of the chosen input. Software or pins can force a specific input, or take a fast external command. In automatic mode the block ranks the qualified inputs itself. It follows either a revertive policy, which always moves to the best candidate, or a non-revertive policy, which stays on the current input until that input fails.

Inputs are numbered 1 to `N_IN`. Index 0 means "no input". Alongside the selection, the block reports the best and runner-up qualified candidates, so supervision logic can see what automatic mode would choose. Every output is registered and reflects the inputs of the previous clock cycle.

Top module: `rc_select`

## Requirements
- R1: An input is qualified only when its validity bit is 1 and its 4-bit priority is non-zero. A priority of 0 removes the input from ranking and from automatic selection.
- R2: Among qualified inputs, a numerically lower priority value ranks higher. Input k (1-based) uses `valid_i[k-1]` and `prio_i[4k-1:4k-4]`.
- R3: When qualified inputs share a priority, the one with the smaller index ranks higher. This applies to the selection and to both ranking outputs.
- R4: `best_idx_o` and `second_idx_o` give the indices of the top two qualified inputs one cycle after the inputs are applied. A rank that has no candidate reads 0.
- R5: With `mode_i` = 01 (forced), `sel_idx_o` takes `force_idx_i` on the next cycle, whether or not that input is qualified.
- R6: With `mode_i` = 10 (external fast), `sel_idx_o` takes `ext_idx_i` on the next cycle, whether or not that input is qualified.
- R7: In automatic mode with `revertive_i` = 1 and at least one qualified input, `sel_idx_o` equals `best_idx_o` on the following cycle.
- R8: In automatic mode with `revertive_i` = 0, the selection stays put while the selected input remains qualified, even if a higher-ranked input appears.
- R9: In automatic non-revertive mode, when the selected input is not qualified, the selection moves to the best qualified input on the next cycle.
- R10: In automatic mode with no qualified input, `sel_idx_o` holds its value and `no_ref_o` is 1. In every other case `no_ref_o` is 0.
- R11: While `rst_ni` is low, all outputs are 0.
- R12: `mode_i` = 11 behaves as automatic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | N_IN | Per-input validity flag, bit k-1 for input k |
| prio_i | input | N_IN*4 | Per-input priority codes, 4 bits each, 0 = disabled |
| mode_i | input | 2 | 00 automatic, 01 forced, 10 external fast, 11 automatic |
| revertive_i | input | 1 | 1 selects revertive automatic policy |
| force_idx_i | input | 4 | Commanded index for forced mode |
| ext_idx_i | input | 4 | Commanded index for external fast mode |
| sel_idx_o | output | 4 | Selected input index |
| best_idx_o | output | 4 | Highest-ranked qualified input, 0 if none |
| second_idx_o | output | 4 | Second-ranked qualified input, 0 if none |
| no_ref_o | output | 1 | Automatic mode found no qualified input |

## Verification
The assertions assume that the validity, priority and mode inputs are synchronous to `clk_i` and stable around its rising edge. They also assume that commanded indices may be any 4-bit value, including out-of-range ones. The stimulus changes every input just after a falling edge and samples outputs just after the following falling edge, so each input pattern is registered by exactly one rising edge. Forced indices deliberately point at unqualified inputs, so that the checks show the commanded selection ignores qualification.

// File: rtl/rc_select_pkg.sv
package rc_select_pkg;
  typedef enum logic [1:0] {
    MODE_AUTO     = 2'b00,
    MODE_FORCED   = 2'b01,
    MODE_EXT      = 2'b10,
    MODE_AUTO_ALT = 2'b11
  } rc_mode_e;

  function automatic logic is_auto(input rc_mode_e m);
    return (m == MODE_AUTO) || (m == MODE_AUTO_ALT);
  endfunction
endpackage

// File: rtl/rc_qual.sv
module rc_qual #(
  parameter int N_IN  = 8,
  parameter int PRI_W = 4
) (
  input  logic [N_IN-1:0]       valid_i,
  input  logic [N_IN*PRI_W-1:0] prio_i,
  output logic [N_IN-1:0]       qual_o
);
  for (genvar g = 0; g < N_IN; g++) begin : g_qual
    assign qual_o[g] = valid_i[g] & (|prio_i[g*PRI_W +: PRI_W]);
  end
endmodule

// File: rtl/rc_rank.sv
module rc_rank #(
  parameter int N_IN  = 8,
  parameter int PRI_W = 4,
  parameter int IDX_W = 4
) (
  input  logic [N_IN-1:0]       qual_i,
  input  logic [N_IN*PRI_W-1:0] prio_i,
  output logic [IDX_W-1:0]      best_o,
  output logic [IDX_W-1:0]      second_o,
  output logic                  any_o
);
  logic [PRI_W-1:0] best_pri, sec_pri;

  // strict compare keeps the lower index on ties
  always_comb begin
    best_o   = '0;
    second_o = '0;
    best_pri = '1;
    sec_pri  = '1;
    for (int i = 0; i < N_IN; i++) begin
      if (qual_i[i]) begin
        if (best_o == '0 || prio_i[i*PRI_W +: PRI_W] < best_pri) begin
          second_o = best_o;
          sec_pri  = best_pri;
          best_o   = IDX_W'(i + 1);
          best_pri = prio_i[i*PRI_W +: PRI_W];
        end else if (second_o == '0 || prio_i[i*PRI_W +: PRI_W] < sec_pri) begin
          second_o = IDX_W'(i + 1);
          sec_pri  = prio_i[i*PRI_W +: PRI_W];
        end
      end
    end
    any_o = |qual_i;
  end
endmodule

// File: rtl/rc_pick.sv
module rc_pick
  import rc_select_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  rc_mode_e         mode_i,
  input  logic             revertive_i,
  input  logic [IDX_W-1:0] force_idx_i,
  input  logic [IDX_W-1:0] ext_idx_i,
  input  logic [N_IN-1:0]  qual_i,
  input  logic [IDX_W-1:0] best_i,
  input  logic             any_i,
  output logic [IDX_W-1:0] sel_o,
  output logic             no_ref_o
);
  logic             cur_qual;
  logic [IDX_W-1:0] sel_d;
  logic             no_ref_d;

  always_comb begin
    cur_qual = 1'b0;
    for (int i = 0; i < N_IN; i++)
      if (sel_o == IDX_W'(i + 1) && qual_i[i]) cur_qual = 1'b1;
  end

  always_comb begin
    sel_d    = sel_o;
    no_ref_d = 1'b0;
    unique case (mode_i)
      MODE_FORCED: sel_d = force_idx_i;
      MODE_EXT:    sel_d = ext_idx_i;
      default: begin
        if (!any_i)                         no_ref_d = 1'b1;
        else if (revertive_i || !cur_qual)  sel_d    = best_i;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o    <= '0;
      no_ref_o <= 1'b0;
    end else begin
      sel_o    <= sel_d;
      no_ref_o <= no_ref_d;
    end
  end

  AST_FORCED_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_FORCED |=> sel_o == $past(force_idx_i)); // R5
  AST_EXT_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_EXT |=> sel_o == $past(ext_idx_i)); // R6
  AST_NONREV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_auto(mode_i) && !revertive_i && cur_qual) |=> $stable(sel_o)); // R8
  AST_NONREV_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_auto(mode_i) && !revertive_i && !cur_qual && any_i) |=> sel_o == $past(best_i)); // R9
  AST_NOREF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_auto(mode_i) && !any_i) |=> (no_ref_o && $stable(sel_o))); // R10
endmodule

// File: rtl/rc_select.sv
module rc_select
  import rc_select_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int PRI_W = 4,
  parameter int IDX_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_IN-1:0]       valid_i,
  input  logic [N_IN*PRI_W-1:0] prio_i,
  input  logic [1:0]            mode_i,
  input  logic                  revertive_i,
  input  logic [IDX_W-1:0]      force_idx_i,
  input  logic [IDX_W-1:0]      ext_idx_i,
  output logic [IDX_W-1:0]      sel_idx_o,
  output logic [IDX_W-1:0]      best_idx_o,
  output logic [IDX_W-1:0]      second_idx_o,
  output logic                  no_ref_o
);
  localparam int MAX_IDX = (1 << IDX_W) - 1;

  logic [N_IN-1:0]  qual;
  logic [IDX_W-1:0] best_c, second_c;
  logic             any_c;
  rc_mode_e         mode;

  assign mode = rc_mode_e'(mode_i);

  initial begin
    if (N_IN > MAX_IDX) $error("N_IN does not fit IDX_W");
  end

  rc_qual #(.N_IN(N_IN), .PRI_W(PRI_W)) u_qual (
    .valid_i (valid_i),
    .prio_i  (prio_i),
    .qual_o  (qual)
  );

  rc_rank #(.N_IN(N_IN), .PRI_W(PRI_W), .IDX_W(IDX_W)) u_rank (
    .qual_i   (qual),
    .prio_i   (prio_i),
    .best_o   (best_c),
    .second_o (second_c),
    .any_o    (any_c)
  );

  rc_pick #(.N_IN(N_IN), .IDX_W(IDX_W)) u_pick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .revertive_i (revertive_i),
    .force_idx_i (force_idx_i),
    .ext_idx_i   (ext_idx_i),
    .qual_i      (qual),
    .best_i      (best_c),
    .any_i       (any_c),
    .sel_o       (sel_idx_o),
    .no_ref_o    (no_ref_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_idx_o   <= '0;
      second_idx_o <= '0;
    end else begin
      best_idx_o   <= best_c;
      second_idx_o <= second_c;
    end
  end

  AST_RANK_DISTINCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    second_idx_o != '0 |-> (best_idx_o != '0 && best_idx_o != second_idx_o)); // R4
  AST_REV_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_auto(mode) && revertive_i && any_c) |=> sel_idx_o == best_idx_o); // R7
  AST_NOREF_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_auto(mode) |=> !no_ref_o); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (sel_idx_o == '0 && best_idx_o == '0 && !no_ref_o)); // R11
endmodule

// File: tb/tb_rc_select.sv
module tb_rc_select;
  localparam int N_IN = 8;

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic [N_IN-1:0] valid_i;
  logic [N_IN*4-1:0] prio_i;
  logic [1:0]      mode_i;
  logic            revertive_i;
  logic [3:0]      force_idx_i, ext_idx_i;
  logic [3:0]      sel_idx_o, best_idx_o, second_idx_o;
  logic            no_ref_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk_i = ~clk_i;

  rc_select #(.N_IN(N_IN)) dut (
    .clk_i, .rst_ni, .valid_i, .prio_i, .mode_i, .revertive_i,
    .force_idx_i, .ext_idx_i, .sel_idx_o, .best_idx_o, .second_idx_o, .no_ref_o
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic set_in(input int k, input logic v, input logic [3:0] p);
    valid_i[k-1]     = v;
    prio_i[4*k-4 +: 4] = p;
  endtask

  task automatic t_reset();
    chk("R11 sel", sel_idx_o, 0);
    chk("R11 best", best_idx_o, 0);
    chk("R11 second", second_idx_o, 0);
    chk("R11 no_ref", no_ref_o, 0);
  endtask

  task automatic t_rank();
    mode_i = 2'b01; force_idx_i = 4'd0;
    set_in(1, 1, 4'd5); set_in(2, 1, 4'd3); set_in(3, 1, 4'd3);
    set_in(4, 1, 4'd0); set_in(5, 0, 4'd2);
    tick();
    chk("R3 best tie", best_idx_o, 2);
    chk("R3 second tie", second_idx_o, 3);
    set_in(2, 0, 4'd3); set_in(3, 0, 4'd3); set_in(1, 0, 4'd5);
    tick();
    chk("R1 prio0 excluded best", best_idx_o, 0);
    chk("R4 empty second", second_idx_o, 0);
    set_in(1, 1, 4'd5); set_in(2, 1, 4'd3); set_in(3, 1, 4'd3); set_in(5, 1, 4'd2);
    tick();
    chk("R2 lower value wins", best_idx_o, 5);
    chk("R2 second", second_idx_o, 2);
  endtask

  task automatic t_rev();
    mode_i = 2'b00; revertive_i = 1'b1;
    tick();
    chk("R7 sel=best", sel_idx_o, 5);
    set_in(5, 0, 4'd2);
    tick();
    chk("R7 fail over", sel_idx_o, 2);
    set_in(5, 1, 4'd2);
    tick();
    chk("R7 revert", sel_idx_o, 5);
    chk("R10 no_ref low", no_ref_o, 0);
  endtask

  task automatic t_nonrev();
    revertive_i = 1'b0;
    set_in(1, 1, 4'd1);
    tick();
    chk("R8 best moved", best_idx_o, 1);
    chk("R8 hold", sel_idx_o, 5);
    tick();
    chk("R8 still hold", sel_idx_o, 5);
    set_in(5, 1, 4'd0);
    tick();
    chk("R9 switch", sel_idx_o, 1);
  endtask

  task automatic t_noref();
    valid_i = '0;
    tick();
    chk("R10 hold sel", sel_idx_o, 1);
    chk("R10 no_ref", no_ref_o, 1);
    chk("R4 none best", best_idx_o, 0);
    revertive_i = 1'b1;
    tick();
    chk("R10 hold rev", sel_idx_o, 1);
  endtask

  task automatic t_force();
    mode_i = 2'b01; force_idx_i = 4'd7;
    tick();
    chk("R5 forced unqualified", sel_idx_o, 7);
    chk("R10 no_ref off forced", no_ref_o, 0);
  endtask

  task automatic t_ext();
    mode_i = 2'b10; ext_idx_i = 4'd3;
    tick();
    chk("R6 external", sel_idx_o, 3);
    ext_idx_i = 4'd12;
    tick();
    chk("R6 external out of range", sel_idx_o, 12);
  endtask

  task automatic t_mode3();
    set_in(6, 1, 4'd4); set_in(8, 1, 4'd4);
    mode_i = 2'b11; revertive_i = 1'b1;
    tick();
    chk("R12 alt auto", sel_idx_o, 6);
    chk("R3 second tie high idx", second_idx_o, 8);
    mode_i = 2'b00; revertive_i = 1'b0; force_idx_i = 4'd7;
    mode_i = 2'b01;
    tick();
    mode_i = 2'b00;
    tick();
    chk("R9 leave unqualified forced", sel_idx_o, 6);
  endtask

  initial begin
    rst_ni = 1'b0; valid_i = '0; prio_i = '0; mode_i = 2'b00;
    revertive_i = 1'b1; force_idx_i = '0; ext_idx_i = '0;
    #20;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_rank();
    t_rev();
    t_nonrev();
    t_noref();
    t_force();
    t_ext();
    t_mode3();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule